// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a bit-level slave for a serial EEPROM on a two-wire bus. It takes the sampled levels of the clock and data wires once per system clock. From these levels it finds start and stop conditions and counts bus clock cycles inside a transfer. It shifts in a header byte, address bytes and write data, and it shifts out read data. All of this uses one shared cycle counter. The storage is an internal byte array.

A static `mode` input picks one of three addressing schemes. The first is a legacy 128-byte scheme, where the header byte holds a 7-bit word address. The second takes one address byte after a select byte and adds three select bits as the upper address bits. The third takes two address bytes. The slave never drives the data wire high. `sda_pull` asks the pad to pull the wire low, and `sda_rd` gives the level the master would see on the wire.

Top module: `twi_eeprom_slave`

## Requirements
- R1: The data input falling while the clock input stays high is a start: the transfer becomes active and the cycle count becomes 0. The data input rising while the clock stays high is a stop: the transfer ends. While no transfer is active, `sda_pull` is 0 and `sda_rd` equals the data level last sampled from the master.
- R2: While active, each rising bus clock first increments the cycle count. Bus data bits are taken on the falling bus clock. Bits are sent MSB first.
- R3: On cycle counts 9, 18 and 27 of an active transfer, no bit is latched and `sda_pull` is 1, so `sda_rd` is 0.
- R4: Legacy mode (`mode`=00): the first byte holds word address bits 6:0 in its bits 7:1 and the read flag (1 = read) in bit 0. Data starts at cycle 10, and a rising clock that would reach 18 sets the count to 9.
- R5: Legacy mode writes: after each written byte, only word-address bits 1:0 advance, so writes wrap inside a 4-byte page.
- R6: Legacy mode reads: at each byte wrap, the word address advances by one modulo 128.
- R7: Single-address mode (`mode`=01): the select byte (read flag in bit 0) is followed by one address byte. When that byte completes, select bits 3:1 become address bits 10:8. Data then runs on cycles 19 to 26, and a count that would reach 27 returns to 18.
- R8: Double-address mode (`mode`=10): the select byte is followed by the high address byte and then the low address byte, which form a 13-bit address. Data runs on cycles 28 to 35, and a count that would reach 36 returns to 27. The array is indexed by the low log2(DEPTH) address bits.
- R9: In the two non-legacy modes, each written byte advances only address bits 3:0, so writes wrap inside a 16-byte page.
- R10: In the two non-legacy modes, a read that follows a restart begins at the address latched before it. A count that would reach 18 returns to 9, and the address advances by one (modulo 2^11 in single mode, 2^13 in double mode).
- R11: Read data appears on cycles 10 to 17, with bit 17 minus the count shown at each count. The slave pulls low for a 0 bit and releases for a 1 bit.
- R12: Clock and data activity with no preceding start leaves the stored bytes unchanged.
- R13: A synchronous reset ends any transfer, clears the count, the address and the select byte, and releases the data line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | Addressing scheme: 00 legacy, 01 single address byte, 10 double address byte |
| scl_i | input | 1 | Sampled bus clock level |
| sda_i | input | 1 | Sampled bus data level driven by the master |
| sda_pull | output | 1 | 1 = pull the data wire low |
| sda_rd | output | 1 | Data level the master reads back |

## Verification
Two pairs of events can land on the same bus edge. The first pair is the last falling edge of a written byte and the page-local address step: this edge both stores the final bit and moves the address. The bench writes five or more bytes from addresses near a page end and then reads the page back, so a wrong wrap shows up as a misplaced byte. The second pair is the rising edge that ends a read byte, which both sends the count back to 9 and advances the address. Sequential reads across the top of the address space test this rise, and the acknowledge pull-down is checked at the same count.

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull,
  output logic       sda_rd
);

  logic [7:0]  mem [DEPTH];
  logic        scl_q, sda_q, started;
  logic [5:0]  cyc;
  logic [12:0] addr;
  logic [7:0]  sel;

  wire legacy   = (mode == 2'b00);
  wire dbl      = mode[1];
  wire start_c  = scl_q & scl_i & sda_q & ~sda_i;
  wire stop_c   = scl_q & scl_i & ~sda_q & sda_i;
  wire rise     = started & ~scl_q & scl_i;
  wire fall     = started & scl_q & ~scl_i;
  wire rd       = legacy ? addr[0] : sel[0];
  wire ack_cyc  = (cyc == 6'd9) | (cyc == 6'd18) | (cyc == 6'd27);
  wire hdr_cyc  = (cyc >= 6'd1) & (cyc <= 6'd8);
  wire data_cyc = legacy ? (cyc > 6'd9) : dbl ? (cyc > 6'd27) : (cyc > 6'd18);
  wire [5:0] cyc_inc = cyc + 6'd1;
  wire [AW-1:0] idx  = legacy ? AW'(addr[7:1]) : addr[AW-1:0];
  wire [2:0] bsel    = 3'(6'd17 - cyc);
  wire rd_phase = started & rd & (cyc >= 6'd10) & (cyc <= 6'd17);
  wire rd_bit   = mem[idx][bsel];
  wire wr_en    = !rst & fall & !ack_cyc & data_cyc & !rd;
  wire [12:0] amask  = dbl ? 13'h1fff : 13'h07ff;
  wire [12:0] a_shft = {addr[11:0], sda_i};

  assign sda_pull = started & (ack_cyc | (rd_phase & ~rd_bit));
  assign sda_rd   = sda_pull ? 1'b0 : (rd_phase ? 1'b1 : sda_q);

  always_ff @(posedge clk)
    if (wr_en) mem[idx] <= {mem[idx][6:0], sda_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      started <= 1'b0;
      cyc <= '0;
      addr <= '0;
      sel <= '0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (start_c) begin
        started <= 1'b1;
        cyc <= '0;
      end else if (stop_c) begin
        started <= 1'b0;
      end else if (rise) begin
        if (legacy) begin
          if (cyc_inc == 6'd18) begin
            cyc <= 6'd9;
            if (addr[0]) addr <= {5'b0, addr[7:0] + 8'd2};
          end else cyc <= cyc_inc;
        end else if (sel[0] && cyc_inc == 6'd18) begin
          cyc <= 6'd9;
          addr <= (addr + 13'd1) & amask;
        end else if (!dbl && cyc_inc == 6'd27) cyc <= 6'd18;
        else if (cyc_inc == 6'd36) cyc <= 6'd27;
        else cyc <= cyc_inc;
      end else if (fall && !ack_cyc) begin
        if (legacy) begin
          if (cyc > 6'd9) begin
            if (!addr[0] && cyc == 6'd17) addr[2:1] <= addr[2:1] + 2'd1;
          end else if (hdr_cyc) addr <= {5'b0, a_shft[7:0]};
        end else if (data_cyc) begin
          if (!sel[0] && (cyc == 6'd26 || cyc == 6'd35)) addr[3:0] <= addr[3:0] + 4'd1;
        end else if (cyc > 6'd9) begin
          if (!sel[0]) begin
            if (dbl) addr <= a_shft;
            else if (cyc == 6'd17) addr <= {2'b0, sel[3:1], a_shft[7:0]};
            else addr <= {5'b0, a_shft[7:0]};
          end
        end else if (hdr_cyc) sel <= {sel[6:0], sda_i};
      end
    end
  end

  p_start_r1: assert property (@(posedge clk) disable iff (rst)
    start_c |=> started && cyc == 6'd0);
  p_stop_r1: assert property (@(posedge clk) disable iff (rst)
    stop_c |=> !started);
  p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
    (rise && cyc <= 6'd16) |=> cyc == $past(cyc) + 6'd1);
  p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cyc <= 6'd35);
  p_idle_release_r1: assert property (@(posedge clk) disable iff (rst)
    !started |-> !sda_pull && sda_rd == sda_q);
  p_page4_r5: assert property (@(posedge clk) disable iff (rst)
    (legacy && fall && cyc == 6'd17 && !addr[0]) |=>
      addr[2:1] == $past(addr[2:1]) + 2'd1 && addr[7:3] == $past(addr[7:3]));
  p_hi_bits_r7: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01 && fall && cyc == 6'd17 && !sel[0]) |=> addr[10:8] == $past(sel[3:1]));
  p_reset_r13: assert property (@(posedge clk)
    rst |=> !started && cyc == 6'd0 && !sda_pull);

endmodule

// File: tb/twi_eeprom_slave_test.sv
module twi_eeprom_slave_test;
  localparam int CLK_P = 10;
  localparam int DEPTH = 2048;

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] mode = 2'b00;
  logic scl = 1'b1, sda = 1'b1;
  logic sda_pull, sda_rd;
  int n_tests = 0, n_fail = 0;
  logic [7:0] mdl [DEPTH];

  twi_eeprom_slave #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .mode(mode), .scl_i(scl), .sda_i(sda),
    .sda_pull(sda_pull), .sda_rd(sda_rd));

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set(input logic c, input logic d);
    @(negedge clk); scl = c; sda = d; @(negedge clk);
  endtask

  task automatic bus_start; set(0, 1); set(1, 1); set(1, 0); set(0, 0); endtask
  task automatic bus_stop;  set(0, 0); set(1, 0); set(1, 1); endtask

  task automatic clk_bit(input logic b, output logic r);
    set(0, b); set(1, b); r = sda_rd; set(0, b);
  endtask

  task automatic send_byte(input logic [7:0] v, input string req);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(v[i], r);
    clk_bit(1'b1, r);
    check(req, r, 0);
  endtask

  task automatic read_byte(output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, r); v[i] = r; end
    clk_bit(1'b0, r);
    check("R3 ack on read wrap", r, 0);
  endtask

  task automatic send_header(input int a, input logic rdf);
    if (mode == 2'b00) send_byte({a[6:0], rdf}, "R3/R4 ack header");
    else begin
      send_byte({4'b1010, (mode == 2'b01) ? a[10:8] : 3'b000, 1'b0}, "R3 ack select");
      if (mode == 2'b10) send_byte({3'b000, a[12:8]}, "R3/R8 ack high addr");
      send_byte(a[7:0], "R3 ack addr");
    end
  endtask

  task automatic write_seq(input int a0, input int n, input int seed);
    int a = a0;
    bus_start();
    send_header(a0, 1'b0);
    for (int k = 0; k < n; k++) begin
      logic [7:0] d = 8'((a * 37 + k * 11 + seed) & 255);
      send_byte(d, mode == 2'b00 ? "R5 ack data" : "R9 ack data");
      if (mode == 2'b00) begin
        mdl[a & 127] = d;
        a = (a & 7'h7c) | ((a + 1) & 3);
      end else begin
        mdl[a & (DEPTH - 1)] = d;
        a = (a & ~15) | ((a + 1) & 15);
      end
    end
    bus_stop();
  endtask

  task automatic read_seq(input int a0, input int n, input string req);
    int a = a0;
    logic [7:0] v;
    bus_start();
    if (mode == 2'b00) send_byte({a0[6:0], 1'b1}, "R4 ack read header");
    else begin
      send_header(a0, 1'b0);
      bus_start();
      send_byte({4'b1010, 3'b111, 1'b1}, "R10 ack read select");
    end
    for (int k = 0; k < n; k++) begin
      read_byte(v);
      if (mode == 2'b00) begin
        check(req, v, mdl[a & 127]);
        a = (a + 1) & 127;
      end else begin
        check(req, v, mdl[a & (DEPTH - 1)]);
        a = (a + 1) & ((mode == 2'b01) ? 16'h7ff : 16'h1fff);
      end
    end
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic r;
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R13 reset pull", sda_pull, 0);
    check("R1 idle level", sda_rd, 1);
    set(0, 0);
    check("R1 idle follows master low", sda_rd, 0);
    set(0, 1);
    check("R1 idle follows master high", sda_rd, 1);

    for (int m = 0; m < 3; m++) begin
      mode = 2'(m);
      for (int s = 0; s < 6; s++) begin
        int a;
        case (m)
          0: a = (s * 21 + 2) & 127;
          1: a = (s * 331 + 13) & 16'h7ff;
          default: a = (s * 1237 + 14) & 16'h1fff;
        endcase
        write_seq(a, (m == 0) ? 6 : 18, s + m * 7);
        read_seq((m == 0) ? (a & 7'h7c) : (a & ~15), (m == 0) ? 4 : 16,
                 (m == 0) ? "R5 legacy page" : (m == 1) ? "R7/R9 single page" : "R8/R9 double page");
      end
    end

    mode = 2'b00;
    write_seq(127, 1, 3);
    write_seq(0, 1, 9);
    read_seq(127, 3, "R6 legacy read wrap");
    mode = 2'b01;
    write_seq(16'h7ff, 1, 4);
    write_seq(16'h000, 1, 5);
    read_seq(16'h7fe, 4, "R10 single read wrap");
    mode = 2'b10;
    write_seq(16'h1fff, 1, 6);
    read_seq(16'h1ffd, 5, "R10 double read wrap");

    set(0, 1);
    for (int i = 0; i < 9; i++) begin set(0, i[0]); set(1, i[0]); set(0, i[0]); end
    read_seq(16'h1ffd, 3, "R12 no start ignored");

    mode = 2'b00;
    bus_start();
    send_byte({7'd5, 1'b1}, "R4 ack before reset");
    set(0, 1); set(1, 1);
    for (int i = 0; i < 8; i++) begin set(0, 1); set(1, 1); end
    check("R3 ack held high clock", sda_pull, 1);
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
    check("R13 reset releases", sda_pull, 0);
    check("R13 reset idle level", sda_rd, 1);
    set(0, 1);
    read_seq(5, 2, "R11 read after reset");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule